// File: doc/BRIEF.md
# Hot-Plug Event Notification Registers

This block reports slot insertions and removals to system software through a small register window. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time. Two 32-bit bitmaps record which slot was most recently inserted or removed. An eject register turns a software-written bitmap into a single eject request for one slot. When a hot-plug event arrives, the block updates the bitmaps and the status bit. If the matching enable bit is set, it also raises a one-cycle system control interrupt pulse.

Register reads are combinational from `bus_addr`. Writes take effect on the clock edge where `bus_wr` is high.

The eject request leaves the block on a valid/ready stream. The rules for back-pressure are these:
- `ej_valid` rises one cycle after an accepted eject write.
- `ej_valid` and `ej_slot` then hold steady until a cycle in which `ej_ready` is high.
- The request is taken in that cycle, and `ej_valid` falls after the edge.
- Eject writes are ignored in every cycle where `ej_valid` is high, including the cycle of the hand-over.

The hot-plug event input and the interrupt output are plain pins.

Address map (5-bit byte address):

| Address | Access | Content |
|---|---|---|
| 0x00 | byte | status, low byte |
| 0x01 | byte | status, high byte |
| 0x02 | byte | enable, low byte |
| 0x03 | byte | enable, high byte |
| 0x08 | 32-bit | inserted-slot bitmap |
| 0x0C | 32-bit | removed-slot bitmap |
| 0x10 | 32-bit | eject register |

Byte accesses use `bus_wdata[7:0]`, and the byte is returned in `bus_rdata[7:0]`. Status bit 1 is the hot-plug event bit, and enable bit 1 gates the interrupt for it.

Top module: `hp_gpe_notify`

## Requirements
- R1: After reset, every readable register is 0, `sci` is 0 and `ej_valid` is 0.
- R2: A read of address 0x00 or 0x01 returns the low or high byte of status in `bus_rdata[7:0]`. A read of 0x02 or 0x03 does the same for enable. Bits 31:8 read 0.
- R3: A write to status address 0x00 or 0x01 clears each bit of that byte whose `bus_wdata` bit is 1. Every other status bit keeps its value.
- R4: A write to enable address 0x02 or 0x03 replaces that byte with `bus_wdata[7:0]`. The other byte keeps its value.
- R5: The inserted bitmap (0x08) and the removed bitmap (0x0C) are 32-bit registers that software can fully write and read back.
- R6: A hot-plug event (`hp_event` high) clears both bitmaps. It then sets bit `hp_slot` of the inserted bitmap when `hp_insert`=1, or of the removed bitmap when `hp_insert`=0. It also sets status bit 1. The results are readable after the edge.
- R7: If enable bit 1 (its value before the edge) is 1 when an event arrives, `sci` is high for exactly the one cycle after the event. Otherwise `sci` stays 0.
- R8: An event takes priority over a bus write in the same cycle. Status bit 1 ends set even if the write clears it, and the bitmaps take the event's result rather than the written value.
- R9: A write of a non-zero value V to 0x10 while no request is pending raises `ej_valid` after the edge, with `ej_slot` equal to the index of the lowest 1 bit of V.
- R10: A write of zero to 0x10 produces no eject request.
- R11: While `ej_valid`=1 and `ej_ready`=0, `ej_valid` and `ej_slot` hold. An eject write made while `ej_valid`=1 is ignored. `ej_valid` falls after an edge with `ej_ready`=1.
- R12: Address 0x10 and every unmapped address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hp_event | input | 1 | One-cycle hot-plug event strobe |
| hp_slot | input | 5 | Slot number of the event |
| hp_insert | input | 1 | 1 = insertion, 0 = removal |
| sci | output | 1 | One-cycle interrupt pulse |
| ej_valid | output | 1 | Eject request valid |
| ej_ready | input | 1 | Eject request accepted |
| ej_slot | output | 5 | Slot to eject |

## Verification
The assertions assume several things about the inputs:
- `hp_event` is a single-cycle strobe.
- `hp_slot` is always below the slot count.
- `ej_ready` may change only between edges.

The stimulus raises `hp_event` for exactly one cycle per event and draws slot numbers only from 0 to 31. It drives every input on the falling edge, so nothing changes at the active edge. The interrupt checks never place two events back to back, so each `sci` pulse can be tied to exactly one event.

// File: rtl/hp_gpe_pkg.sv
package hp_gpe_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_STS_BASE = 5'h00;
  localparam logic [ADDR_W-1:0] A_EN_BASE  = 5'h02;
  localparam logic [ADDR_W-1:0] A_INS      = 5'h08;
  localparam logic [ADDR_W-1:0] A_REM      = 5'h0C;
  localparam logic [ADDR_W-1:0] A_EJECT    = 5'h10;
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
  import hp_gpe_pkg::*;
#(
  parameter int BYTES  = 2,
  parameter int HP_BIT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 hp_event,
  output logic [8*BYTES-1:0]   sts,
  output logic [8*BYTES-1:0]   en,
  output logic                 sci
);
  localparam int GPE_W = 8 * BYTES;

  logic [GPE_W-1:0] sts_q, en_q, sts_d, en_d;
  logic             sci_q;

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    for (int b = 0; b < BYTES; b++) begin
      if (wr && addr == A_STS_BASE + ADDR_W'(b))
        sts_d[b*8 +: 8] = sts_q[b*8 +: 8] & ~wdata;
      if (wr && addr == A_EN_BASE + ADDR_W'(b))
        en_d[b*8 +: 8] = wdata;
    end
    if (hp_event) sts_d[HP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      sci_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
      sci_q <= hp_event & en_q[HP_BIT];
    end
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign sci = sci_q;

  // R7
  sci_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci_q |=> !sci_q);
  // R7
  sci_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_event && en_q[HP_BIT]) |=> sci_q);
  // R8
  event_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_event |=> sts_q[HP_BIT]);
  // R3
  status_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_event |=> ((sts_q & ~$past(sts_q)) == '0));
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps
  import hp_gpe_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SLOTS-1:0]         wdata,
  input  logic                     hp_event,
  input  logic [$clog2(SLOTS)-1:0] hp_slot,
  input  logic                     hp_insert,
  output logic [SLOTS-1:0]         ins_map,
  output logic [SLOTS-1:0]         rem_map
);
  logic [SLOTS-1:0] ins_q, rem_q, ins_d, rem_d;

  always_comb begin
    ins_d = ins_q;
    rem_d = rem_q;
    if (hp_event) begin
      ins_d = '0;
      rem_d = '0;
      if (hp_insert) ins_d[hp_slot] = 1'b1;
      else           rem_d[hp_slot] = 1'b1;
    end else if (wr && addr == A_INS) begin
      ins_d = wdata;
    end else if (wr && addr == A_REM) begin
      rem_d = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_q <= '0;
      rem_q <= '0;
    end else begin
      ins_q <= ins_d;
      rem_q <= rem_d;
    end
  end

  assign ins_map = ins_q;
  assign rem_map = rem_q;

  // R6
  event_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_event |=> ($countones({ins_q, rem_q}) == 1));
  // R6
  event_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_event && hp_insert) |=> (rem_q == '0));
endmodule

// File: rtl/hp_eject_port.sv
module hp_eject_port #(
  parameter int SLOTS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ej,
  input  logic [SLOTS-1:0]         wdata,
  output logic                     ej_valid,
  input  logic                     ej_ready,
  output logic [$clog2(SLOTS)-1:0] ej_slot
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] low_idx;
  logic              valid_q;
  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    low_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (wdata[i]) low_idx = SLOT_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
    end else if (valid_q) begin
      if (ej_ready) valid_q <= 1'b0;
    end else if (wr_ej && (|wdata)) begin
      valid_q <= 1'b1;
      slot_q  <= low_idx;
    end
  end

  assign ej_valid = valid_q;
  assign ej_slot  = slot_q;

  // R11
  ej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ej_ready) |=> (valid_q && $stable(slot_q)));
  // R11
  ej_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ej_ready) |=> !valid_q);
  // R10
  ej_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && wr_ej && wdata == '0) |=> !valid_q);
  // R9
  ej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(wr_ej));
endmodule

// File: rtl/hp_gpe_notify.sv
module hp_gpe_notify
  import hp_gpe_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int BYTES  = 2,
  parameter int HP_BIT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     hp_event,
  input  logic [$clog2(SLOTS)-1:0] hp_slot,
  input  logic                     hp_insert,
  output logic                     sci,
  output logic                     ej_valid,
  input  logic                     ej_ready,
  output logic [$clog2(SLOTS)-1:0] ej_slot
);
  localparam int GPE_W = 8 * BYTES;

  logic [GPE_W-1:0] sts, en;
  logic [SLOTS-1:0] ins_map, rem_map;
  logic             wr_ej;

  assign wr_ej = bus_wr && (bus_addr == A_EJECT);

  hp_gpe_regs #(.BYTES(BYTES), .HP_BIT(HP_BIT)) u_gpe (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[7:0]), .hp_event(hp_event),
    .sts(sts), .en(en), .sci(sci)
  );

  hp_slot_maps #(.SLOTS(SLOTS)) u_maps (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[SLOTS-1:0]), .hp_event(hp_event),
    .hp_slot(hp_slot), .hp_insert(hp_insert),
    .ins_map(ins_map), .rem_map(rem_map)
  );

  hp_eject_port #(.SLOTS(SLOTS)) u_eject (
    .clk(clk), .rst_n(rst_n), .wr_ej(wr_ej),
    .wdata(bus_wdata[SLOTS-1:0]),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_slot(ej_slot)
  );

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (bus_addr == A_STS_BASE + ADDR_W'(b)) bus_rdata = DATA_W'(sts[b*8 +: 8]);
      if (bus_addr == A_EN_BASE + ADDR_W'(b))  bus_rdata = DATA_W'(en[b*8 +: 8]);
    end
    if (bus_addr == A_INS) bus_rdata = DATA_W'(ins_map);
    if (bus_addr == A_REM) bus_rdata = DATA_W'(rem_map);
  end
endmodule

// File: tb/hp_gpe_notify_tb.sv
module hp_gpe_notify_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hp_event = 1'b0;
  logic [4:0]  hp_slot = '0;
  logic        hp_insert = 1'b0;
  logic        sci;
  logic        ej_valid;
  logic        ej_ready = 1'b0;
  logic [4:0]  ej_slot;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hp_gpe_notify u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_event(hp_event),
    .hp_slot(hp_slot), .hp_insert(hp_insert), .sci(sci),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_slot(ej_slot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic fire(input logic [4:0] s, input logic ins);
    @(negedge clk);
    hp_event = 1'b1; hp_slot = s; hp_insert = ins;
    @(negedge clk);
    hp_event = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] v, iso;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 unused addresses
    for (int a = 0; a < 32; a++) begin
      bus_read(5'(a), rd);
      check("R1", rd, 32'h0);
    end
    check("R1 sci", {31'b0, sci}, 32'h0);
    check("R1 ej_valid", {31'b0, ej_valid}, 32'h0);

    // R2 / R4 enable byte lanes, sweep all low-byte values
    bus_write(5'h03, 32'hFFFF_FFC3);
    for (int x = 0; x < 256; x++) begin
      bus_write(5'h02, 32'hABCD_EF00 | 32'(x));
      bus_read(5'h02, rd); check("R4 low", rd, 32'(x));
      bus_read(5'h03, rd); check("R2 high kept", rd, 32'hC3);
    end
    bus_write(5'h03, 32'h5A);
    bus_read(5'h02, rd); check("R4 low kept", rd, 32'hFF);
    bus_read(5'h03, rd); check("R4 high", rd, 32'h5A);

    // R5 bitmap read/write
    bus_write(5'h08, 32'h1234_5678);
    bus_write(5'h0C, 32'h8765_4321);
    bus_read(5'h08, rd); check("R5 ins", rd, 32'h1234_5678);
    bus_read(5'h0C, rd); check("R5 rem", rd, 32'h8765_4321);

    // R6 / R7 slot sweep; enable bit 1 toggled by slot parity
    for (int s = 0; s < 32; s++) begin
      for (int ins = 0; ins < 2; ins++) begin
        bus_write(5'h02, (s % 2 == 0) ? 32'h02 : 32'h00);
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_write(5'h0C, 32'hA5A5_A5A5);
        bus_write(5'h00, 32'hFF);
        fire(5'(s), ins[0]);
        check("R7 pulse", {31'b0, sci}, (s % 2 == 0) ? 32'h1 : 32'h0);
        bus_read(5'h08, rd); check("R6 ins", rd, ins ? (32'h1 << s) : 32'h0);
        bus_read(5'h0C, rd); check("R6 rem", rd, ins ? 32'h0 : (32'h1 << s));
        bus_read(5'h00, rd); check("R6 status", rd, 32'h02);
        @(negedge clk);
        check("R7 one cycle", {31'b0, sci}, 32'h0);
      end
    end

    // R3 status clear is per byte and per bit
    bus_write(5'h01, 32'hFF);
    bus_read(5'h00, rd); check("R3 other byte", rd, 32'h02);
    bus_write(5'h00, 32'hFD);
    bus_read(5'h00, rd); check("R3 unwritten bit", rd, 32'h02);
    bus_write(5'h00, 32'h02);
    bus_read(5'h00, rd); check("R3 cleared", rd, 32'h00);

    // R8 event beats same-cycle status clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h02;
    hp_event = 1'b1; hp_slot = 5'd7; hp_insert = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; hp_event = 1'b0;
    bus_read(5'h00, rd); check("R8 status", rd, 32'h02);
    // R8 event beats same-cycle bitmap write
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'hFFFF_0000;
    hp_event = 1'b1; hp_slot = 5'd30; hp_insert = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; hp_event = 1'b0;
    bus_read(5'h0C, rd); check("R8 rem", rd, 32'h4000_0000);
    bus_read(5'h08, rd); check("R8 ins", rd, 32'h0);

    // R9 / R11 eject sweep over lowest-bit position with back-pressure
    for (int i = 0; i < 32; i++) begin
      v = ((32'h9E37_79B9 ^ 32'(i * 77)) << i) | (32'h1 << i);
      iso = v & (~v + 32'h1);
      bus_write(5'h10, v);
      check("R9 valid", {31'b0, ej_valid}, 32'h1);
      check("R9 slot", 32'(ej_slot), 32'($clog2(iso)));
      bus_write(5'h10, 32'h8000_0000);
      check("R11 hold valid", {31'b0, ej_valid}, 32'h1);
      check("R11 hold slot", 32'(ej_slot), 32'($clog2(iso)));
      bus_read(5'h10, rd); check("R12 eject reads 0", rd, 32'h0);
      ej_ready = 1'b1;
      @(negedge clk);
      ej_ready = 1'b0;
      check("R11 release", {31'b0, ej_valid}, 32'h0);
    end

    // R10 zero write makes no request
    bus_write(5'h10, 32'h0);
    check("R10 no request", {31'b0, ej_valid}, 32'h0);
    @(negedge clk);
    check("R10 still none", {31'b0, ej_valid}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule